// File: doc/BRIEF.md
# Indirect Word Memory Window

This block gives a host a path into a local word-addressed memory through two 32-bit registers on a small register bus. A control register holds the current address, split into a block number and a word offset inside that block, plus two auto-increment enables: one for data writes and one for data reads. A data register moves one 32-bit word per access at the current address. With the matching enable set, each data access advances the address by one word. A host can then stream a whole buffer in or out after a single control write.

The host first writes the control register to place the address and choose the enables. It then issues a run of data writes or data reads. Read results come back one cycle after the request with a valid strobe. Reading the control register shows how far a burst has moved the address. The address is a 14-bit word index: the block number in the upper 8 bits and the offset in the lower 6 bits. Storage decodes only the low `MEM_BLK_W` bits of the block number. The default keeps the RAM small. Setting the parameter to 8 gives the full 256 blocks of 256 bytes.

Top module: `idx_mem_port`

## Requirements
- R1: After reset the offset, the block number and both enables are zero, a control read returns 0x00000000, and `bus_rvalid` is low.
- R2: The control register is at window offset 0x0 and the data register at 0x4, decoded from `bus_addr[2]` alone (address bits 1:0 are ignored). In a control word, bits 7:2 hold the word offset, bits 15:8 the block, bit 24 the write-increment enable and bit 25 the read-increment enable. Bits 1:0, 23:16 and 31:26 read as zero.
- R3: A data write stores all 32 bits at word index block*64+offset. A later data read at that index returns the same 32 bits, with byte 0 in bits 7:0.
- R4: Every read request, to either register, raises `bus_rvalid` for exactly the next cycle, with `bus_rdata` valid in that cycle. With no read request, `bus_rvalid` stays low.
- R5: A data write advances the address by one word when the write enable is set and leaves it unchanged when that enable is clear.
- R6: A data read advances the address by one word when the read enable is set, after the word at the old address has been captured. With the enable clear, the address is left unchanged.
- R7: Each enable acts only on its own direction. The write enable never moves the address on a read, and the read enable never moves it on a write.
- R8: An advance from offset 63 wraps the offset to 0 and carries into the block number. Block 255 wraps to block 0.
- R9: Data accesses may be issued on every cycle. Each access uses the address left by the one before it.
- R10: The block field keeps all 8 bits for read-back and carry. Storage uses only its low `MEM_BLK_W` bits, so blocks that differ only above those bits reach the same words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW (3) | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
Read data and its valid strobe are due one cycle after the request, because one register stage lies on the path. Address changes from a control write or a stepped data access become visible to the access issued in the following cycle. The bench drives each request on a falling edge and checks the result of the previous cycle's read on the next falling edge, while issuing a new request in the same step. This keeps the timing check exact when accesses run back to back. The bench checks `bus_rvalid` in every cycle, so a missing or extra strobe is caught in the cycle it occurs.

// File: rtl/idx_mem_pkg.sv
package idx_mem_pkg;
  localparam int OFF_W    = 6;
  localparam int BLK_W    = 8;
  localparam int LIN_W    = OFF_W + BLK_W;
  localparam int OFF_LSB  = 2;
  localparam int BLK_LSB  = 8;
  localparam int WINC_BIT = 24;
  localparam int RINC_BIT = 25;
  localparam int SEL_BIT  = 2;

  typedef struct packed {
    logic             rinc;
    logic             winc;
    logic [BLK_W-1:0] blk;
    logic [OFF_W-1:0] off;
  } ctrl_t;

  function automatic logic [31:0] ctrl_to_word(ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[OFF_LSB +: OFF_W] = c.off;
    w[BLK_LSB +: BLK_W] = c.blk;
    w[WINC_BIT]         = c.winc;
    w[RINC_BIT]         = c.rinc;
    return w;
  endfunction

  function automatic ctrl_t word_to_ctrl(logic [31:0] w);
    ctrl_t c;
    c.off  = w[OFF_LSB +: OFF_W];
    c.blk  = w[BLK_LSB +: BLK_W];
    c.winc = w[WINC_BIT];
    c.rinc = w[RINC_BIT];
    return c;
  endfunction
endpackage

// File: rtl/idx_addr_ctrl.sv
module idx_addr_ctrl
  import idx_mem_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld,
  input  ctrl_t ld_val,
  input  logic  wr_step,
  input  logic  rd_step,
  output ctrl_t ctrl_q
);
  ctrl_t            ctrl_d;
  logic             adv;
  logic [LIN_W-1:0] lin_q;
  logic [LIN_W-1:0] lin_inc;

  assign lin_q   = {ctrl_q.blk, ctrl_q.off};
  assign lin_inc = lin_q + LIN_W'(1);
  assign adv     = (wr_step && ctrl_q.winc) || (rd_step && ctrl_q.rinc);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ld) begin
      ctrl_d = ld_val;
    end else if (adv) begin
      {ctrl_d.blk, ctrl_d.off} = lin_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ld || adv) begin
      ctrl_q <= ctrl_d;
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (ctrl_q == $past(ld_val)));

  p_wr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_step && !ld && ctrl_q.winc) |=> (lin_q == LIN_W'($past(lin_q) + LIN_W'(1))));

  p_rd_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && !ld && ctrl_q.rinc) |=> (lin_q == LIN_W'($past(lin_q) + LIN_W'(1))));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !(wr_step && ctrl_q.winc) && !(rd_step && ctrl_q.rinc)) |=> $stable(ctrl_q));
endmodule

// File: rtl/idx_mem_ram.sv
module idx_mem_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    if (re) begin
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/idx_mem_port.sv
module idx_mem_port
  import idx_mem_pkg::*;
#(
  parameter int MEM_BLK_W = 4,
  parameter int BUS_AW    = 3,
  localparam int WORD_AW  = MEM_BLK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);
  logic               is_data;
  logic               ctrl_wr, data_wr, data_rd, ctrl_rd;
  ctrl_t              ctrl_q;
  ctrl_t              ld_val;
  logic [WORD_AW-1:0] word_idx;
  logic [31:0]        ram_q;
  logic               rvalid_q, rvalid_d;
  logic               rsel_q, rsel_d;
  logic [31:0]        snap_q, snap_d;
  logic               unused_bits;

  assign is_data = bus_addr[SEL_BIT];
  assign ctrl_wr = bus_sel &&  bus_wr && !is_data;
  assign data_wr = bus_sel &&  bus_wr &&  is_data;
  assign ctrl_rd = bus_sel && !bus_wr && !is_data;
  assign data_rd = bus_sel && !bus_wr &&  is_data;
  assign ld_val  = word_to_ctrl(bus_wdata);

  assign unused_bits = ^{bus_addr, bus_wdata, ctrl_q.blk};

  idx_addr_ctrl u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (ctrl_wr),
    .ld_val  (ld_val),
    .wr_step (data_wr),
    .rd_step (data_rd),
    .ctrl_q  (ctrl_q)
  );

  assign word_idx = {ctrl_q.blk[MEM_BLK_W-1:0], ctrl_q.off};

  idx_mem_ram #(
    .DATA_W (32),
    .ADDR_W (WORD_AW)
  ) u_ram (
    .clk   (clk),
    .we    (data_wr),
    .re    (data_rd),
    .addr  (word_idx),
    .wdata (bus_wdata),
    .rdata (ram_q)
  );

  always_comb begin
    rvalid_d = bus_sel && !bus_wr;
    rsel_d   = rsel_q;
    snap_d   = snap_q;
    if (data_rd) begin
      rsel_d = 1'b1;
    end
    if (ctrl_rd) begin
      rsel_d = 1'b0;
      snap_d = ctrl_to_word(ctrl_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rsel_q   <= 1'b0;
      snap_q   <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      if (bus_sel && !bus_wr) begin
        rsel_q <= rsel_d;
        snap_q <= snap_d;
      end
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rsel_q ? ram_q : snap_q;

  p_rvalid_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  p_rvalid_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> !bus_rvalid);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && !rsel_q) |-> (bus_rdata[1:0] == 2'b00 && bus_rdata[23:16] == 8'h00
                                 && bus_rdata[31:26] == 6'h00));
endmodule

// File: tb/tb_idx_mem_port.sv
module tb_idx_mem_port;
  localparam int MBW   = 4;
  localparam int NWORD = 1 << (MBW + 6);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  always #4 clk = ~clk;

  idx_mem_port #(.MEM_BLK_W(MBW), .BUS_AW(3)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  int nvec = 0;
  int nfail = 0;

  logic [5:0]  m_off;
  logic [7:0]  m_blk;
  logic        m_aw, m_ar;
  logic [31:0] mdl [NWORD];

  logic        pend;
  logic [31:0] pend_exp;
  string       pend_tag;

  function automatic logic [31:0] m_ctrl();
    return {6'b0, m_ar, m_aw, 8'h00, m_blk, m_off, 2'b00};
  endfunction

  function automatic int m_idx();
    return int'({m_blk[MBW-1:0], m_off});
  endfunction

  task automatic bump();
    {m_blk, m_off} = {m_blk, m_off} + 14'd1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic [2:0] a,
                      input logic [31:0] d, input string tag);
    @(negedge clk);
    if (pend) begin
      chk("R4", {31'b0, bus_rvalid}, 32'd1);
      chk(pend_tag, bus_rdata, pend_exp);
    end else begin
      chk("R4", {31'b0, bus_rvalid}, 32'd0);
    end
    pend = 1'b0;
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    if (s) begin
      if (w && !a[2]) begin
        m_off = d[7:2]; m_blk = d[15:8]; m_aw = d[24]; m_ar = d[25];
      end else if (w) begin
        mdl[m_idx()] = d;
        if (m_aw) bump();
      end else begin
        pend = 1'b1; pend_tag = tag;
        if (!a[2]) pend_exp = m_ctrl();
        else begin
          pend_exp = mdl[m_idx()];
          if (m_ar) bump();
        end
      end
    end
  endtask

  task automatic cw(input logic [31:0] d);  step(1, 1, 3'h0, d, "R2"); endtask
  task automatic dw(input logic [31:0] d);  step(1, 1, 3'h4, d, "R3"); endtask
  task automatic cr(input string t);        step(1, 0, 3'h0, 0, t);    endtask
  task automatic dr(input string t);        step(1, 0, 3'h4, 0, t);    endtask
  task automatic idle();                    step(0, 0, 3'h0, 0, "R4"); endtask

  function automatic logic [31:0] cword(int off, int blk, bit aw, bit ar);
    return {6'b0, ar, aw, 8'h00, 8'(blk), 6'(off), 2'b00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20817));
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    pend = 0; m_off = 0; m_blk = 0; m_aw = 0; m_ar = 0;
    repeat (3) @(negedge clk);
    chk("R1", {31'b0, bus_rvalid}, 32'd0);
    rst_n = 1'b1;
    cr("R1");
    // Fill all storage with a write burst, then read it back back-to-back (R9, R3)
    cw(cword(0, 0, 1, 0));
    for (int i = 0; i < NWORD; i++) dw({16'(i), ~16'(i)});
    cr("R5");
    cw(cword(0, 0, 0, 1));
    for (int i = 0; i < NWORD; i++) dr("R9");
    cr("R6");
    // Little-endian byte lanes (R3)
    cw(cword(9, 1, 0, 0));
    dw(32'h44332211);
    dr("R3");
    // Reserved bits and decode (R2): address bits 1:0 ignored
    cw(32'hFFFF_FFFF);
    cr("R2");
    step(1, 0, 3'h3, 0, "R2");
    step(1, 1, 3'h5, 32'hA5A5_0F0F, "R2");
    cw(cword(0, 8'hFF, 0, 0));
    cw(cword(62, 8'hFE, 0, 0));
    cr("R2");
    // Write step on/off (R5)
    cw(cword(5, 2, 1, 0));
    dw(32'h1111_0001); dw(32'h1111_0002);
    cr("R5");
    cw(cword(7, 2, 0, 0));
    dw(32'h2222_0003); dw(32'h2222_0004);
    cr("R5");
    dr("R5");
    // Read step on/off (R6)
    cw(cword(5, 2, 0, 1));
    dr("R6"); dr("R6"); cr("R6");
    cw(cword(5, 2, 0, 0));
    dr("R6"); dr("R6"); cr("R6");
    // Independence (R7)
    cw(cword(20, 3, 1, 0));
    dr("R7"); dr("R7"); cr("R7");
    cw(cword(20, 3, 0, 1));
    dw(32'h3333_0005); cr("R7"); dr("R7"); cr("R7");
    // Wrap and carry (R8)
    cw(cword(63, 8'hFF, 1, 0));
    dw(32'h4444_0006); cr("R8");
    cw(cword(63, 3, 0, 1));
    dr("R8"); cr("R8"); dr("R8");
    // Aliasing of upper block bits (R10)
    cw(cword(11, 8'h13, 0, 0));
    dw(32'h5555_0007);
    cw(cword(11, 8'h03, 0, 0));
    dr("R10"); cr("R10");
    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 2) begin
        if ($urandom % 2) cw(cword(60 + int'($urandom % 4), (r == 0) ? 8'hFF : int'($urandom % 256),
                                   1'($urandom), 1'($urandom)));
        else cw($urandom);
      end else if (r < 7) dw($urandom);
      else if (r < 12) dr("R9");
      else if (r < 14) cr("R2");
      else idle();
    end
    idle(); idle();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule